// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block examines one 16-bit instruction word together with the program counter (already advanced past that word) and the four condition flags N, Z, V and C. It decides whether the word is a conditional or unconditional relative branch and whether that branch is taken. It returns the address from which execution continues. A branch is always a single word. Its 8-bit displacement counts words, is signed, and is applied to the advanced program counter, so the reach is -128 to +127 words around the word that follows the branch.

Operands enter through a valid/ready stream and the result leaves through a second valid/ready stream with one register stage in between. An operand transfers on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds unchanged and no new operand is accepted. The byte-swap encoding, which occupies the slot an always-branch variant would use, is reported as a non-branch.

Top module: `cond_branch_eval`

## Requirements
- R1: Out of reset `out_valid` is low and `in_ready` is high.
- R2: An operand accepted on a clock edge (`in_valid` and `in_ready` high) appears on the outputs with `out_valid` high after that same edge.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_is_branch`, `out_taken` and `out_target` hold their values.
- R4: `out_is_branch` is high exactly when bits [14:11] of the word are zero and the 4-bit code {bit 15, bits [10:8]} is not 0000.
- R5: A word with bits [15:6] = 0000000011 (byte swap) gives `out_is_branch` low and `out_taken` low.
- R6: For codes 0001 to 0111 the taken conditions are, in order: always, !Z, Z, !(N^V), N^V, !(Z|(N^V)), Z|(N^V). Flags are packed as `in_flags` = {N, Z, V, C} with N in bit 3.
- R7: For codes 1000 to 1111 the taken conditions are, in order: !N, N, !(C|Z), C|Z, !V, V, !C, C.
- R8: When taken, `out_target` = `in_pc` + 2 * sign_extend(bits [7:0]), modulo 2^ADDR_W.
- R9: When the word is not a branch, or the branch is not taken, `out_target` equals `in_pc`.
- R10: `out_taken` is never high while `out_is_branch` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_instr | input | 16 | Instruction word |
| in_pc | input | ADDR_W | Program counter already advanced past the word |
| in_flags | input | 4 | {N, Z, V, C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_is_branch | output | 1 | Word is a relative branch |
| out_taken | output | 1 | Branch condition holds |
| out_target | output | ADDR_W | Address to continue from |

## Verification
Directed words cover every one of the fifteen branch codes with flag sets that satisfy and violate each condition, which separates the signed comparisons (N^V) from the unsigned ones (C|Z). Displacements 0x7F, 0x80, 0x00 and 0xFF, together with a program counter near the top and bottom of the address space, distinguish correct sign extension, word scaling and wrap from byte scaling or unsigned offset. The byte-swap word and other words with a nonzero bits [14:11] show that non-branches leave the target at the advanced program counter. A random mix of branch-shaped and arbitrary words with fixed-seed flags, along with a stall sequence on `out_ready`, checks decode breadth and result holding under back-pressure.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cbe_flags_t;

  typedef enum logic [3:0] {
    COND_NONE,
    COND_ALWAYS,
    COND_NE,
    COND_EQ,
    COND_GE,
    COND_LT,
    COND_GT,
    COND_LE,
    COND_PL,
    COND_MI,
    COND_HI,
    COND_LOS,
    COND_VC,
    COND_VS,
    COND_CC,
    COND_CS
  } cbe_cond_e;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned DISP_W  = 8;

endpackage

// File: rtl/cbe_decode.sv
module cbe_decode
  import cbe_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output cbe_cond_e          cond,
  output logic               is_branch,
  output logic [DISP_W-1:0]  disp
);

  logic [3:0] code;
  logic       family_ok;

  assign code      = {instr[15], instr[10:8]};
  assign family_ok = (instr[14:11] == 4'b0000);
  assign disp      = instr[DISP_W-1:0];

  // Code 0000 covers the byte swap pattern and other non-branch words.
  always_comb begin
    cond = COND_NONE;
    if (family_ok) begin
      case (code)
        4'b0001: cond = COND_ALWAYS;
        4'b0010: cond = COND_NE;
        4'b0011: cond = COND_EQ;
        4'b0100: cond = COND_GE;
        4'b0101: cond = COND_LT;
        4'b0110: cond = COND_GT;
        4'b0111: cond = COND_LE;
        4'b1000: cond = COND_PL;
        4'b1001: cond = COND_MI;
        4'b1010: cond = COND_HI;
        4'b1011: cond = COND_LOS;
        4'b1100: cond = COND_VC;
        4'b1101: cond = COND_VS;
        4'b1110: cond = COND_CC;
        4'b1111: cond = COND_CS;
        default: cond = COND_NONE;
      endcase
    end
  end

  assign is_branch = (cond != COND_NONE);

endmodule

// File: rtl/cbe_cond_eval.sv
module cbe_cond_eval
  import cbe_pkg::*;
(
  input  cbe_cond_e  cond,
  input  cbe_flags_t flags,
  output logic       taken
);

  logic sgn_lt;
  logic sgn_le;
  logic uns_le;

  assign sgn_lt = flags.n ^ flags.v;
  assign sgn_le = flags.z | sgn_lt;
  assign uns_le = flags.c | flags.z;

  always_comb begin
    unique case (cond)
      COND_NONE:   taken = 1'b0;
      COND_ALWAYS: taken = 1'b1;
      COND_NE:     taken = ~flags.z;
      COND_EQ:     taken = flags.z;
      COND_GE:     taken = ~sgn_lt;
      COND_LT:     taken = sgn_lt;
      COND_GT:     taken = ~sgn_le;
      COND_LE:     taken = sgn_le;
      COND_PL:     taken = ~flags.n;
      COND_MI:     taken = flags.n;
      COND_HI:     taken = ~uns_le;
      COND_LOS:    taken = uns_le;
      COND_VC:     taken = ~flags.v;
      COND_VS:     taken = flags.v;
      COND_CC:     taken = ~flags.c;
      COND_CS:     taken = flags.c;
      default:     taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbe_target.sv
module cbe_target
  import cbe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc_next,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [ADDR_W-1:0] target
);

  localparam int unsigned SCALED_W = DISP_W + 1;

  logic [SCALED_W-1:0] scaled;
  logic [ADDR_W-1:0]   offset;

  // Word displacement becomes a byte offset.
  assign scaled = {disp, 1'b0};

  generate
    if (ADDR_W > SCALED_W) begin : g_extend
      assign offset = {{(ADDR_W-SCALED_W){disp[DISP_W-1]}}, scaled};
    end else begin : g_trunc
      assign offset = scaled[ADDR_W-1:0];
    end
  endgenerate

  assign target = taken ? (pc_next + offset) : pc_next;

endmodule

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
  import cbe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_instr,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_branch,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target
);

  cbe_cond_e         cond;
  cbe_flags_t        flags;
  logic              dec_branch;
  logic [DISP_W-1:0] disp;
  logic              cond_taken;
  logic [ADDR_W-1:0] next_target;
  logic              accept;

  assign flags = cbe_flags_t'(in_flags);

  cbe_decode u_decode (
    .instr     (in_instr),
    .cond      (cond),
    .is_branch (dec_branch),
    .disp      (disp)
  );

  cbe_cond_eval u_cond (
    .cond  (cond),
    .flags (flags),
    .taken (cond_taken)
  );

  cbe_target #(.ADDR_W(ADDR_W)) u_target (
    .pc_next (in_pc),
    .disp    (disp),
    .taken   (cond_taken),
    .target  (next_target)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_is_branch <= 1'b0;
      out_taken     <= 1'b0;
      out_target    <= '0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_is_branch <= dec_branch;
      out_taken     <= cond_taken;
      out_target    <= next_target;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

endmodule

// File: rtl/cond_branch_eval_chk.sv
module cond_branch_eval_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       in_instr,
  input logic [ADDR_W-1:0] in_pc,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_branch,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_target
);

  a_r2_accept_presents: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r3_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_stall_holds_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target)
                                   && $stable(out_taken) && $stable(out_is_branch)));

  a_r5_swab_not_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[15:6] == 10'b0000000011)
      |=> (!out_is_branch && !out_taken));

  a_r6_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[15:8] == 8'h01) |=> (out_is_branch && out_taken));

  a_r9_nonbranch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[14:11] != 4'b0000) |=> (out_target == $past(in_pc)));

  a_r10_taken_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_taken || out_is_branch));

endmodule

bind cond_branch_eval cond_branch_eval_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_instr      (in_instr),
  .in_pc         (in_pc),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_is_branch (out_is_branch),
  .out_taken     (out_taken),
  .out_target    (out_target)
);

// File: tb/cond_branch_eval_test.sv
module cond_branch_eval_test;

  localparam int unsigned AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_instr = '0;
  logic [AW-1:0] in_pc = '0;
  logic [3:0]    in_flags = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_is_branch;
  logic          out_taken;
  logic [AW-1:0] out_target;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cond_branch_eval #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc(in_pc), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_is_branch(out_is_branch), .out_taken(out_taken), .out_target(out_target)
  );

  function automatic logic exp_branch(input logic [15:0] w);
    return (w[14:11] == 4'd0) && ({w[15], w[10:8]} != 4'd0);
  endfunction

  function automatic logic exp_taken(input logic [15:0] w, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    if (!exp_branch(w)) return 1'b0;
    case ({w[15], w[10:8]})
      4'd1:  return 1'b1;
      4'd2:  return !z;
      4'd3:  return z;
      4'd4:  return n == v;
      4'd5:  return n != v;
      4'd6:  return !z && (n == v);
      4'd7:  return z || (n != v);
      4'd8:  return !n;
      4'd9:  return n;
      4'd10: return !c && !z;
      4'd11: return c || z;
      4'd12: return !v;
      4'd13: return v;
      4'd14: return !c;
      default: return c;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_target(input logic [15:0] w, input logic [AW-1:0] pc,
                                                input logic [3:0] f);
    int signed d;
    if (!exp_taken(w, f)) return pc;
    d = int'($signed(w[7:0])) * 2;
    return AW'(int'(pc) + d);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input string req, input logic [15:0] w, input logic [AW-1:0] pc,
                         input logic [3:0] f);
    @(negedge clk);
    in_instr = w; in_pc = pc; in_flags = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "out_valid", int'(out_valid), 1);
    check(req, "is_branch R4", int'(out_is_branch), int'(exp_branch(w)));
    check(req, "taken R6/R7", int'(out_taken), int'(exp_taken(w, f)));
    check(req, "target R8/R9", int'(out_target), int'(exp_target(w, pc, f)));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);

    // R6 and R7: every code, each flag pattern
    for (int code = 1; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        run_one(code < 8 ? "R6" : "R7",
                {code[3], 4'b0000, code[2:0], 8'h05}, 16'h1000, f[3:0]);
      end
    end

    // R8 displacement corners
    run_one("R8", 16'h017F, 16'h2000, 4'h0);
    run_one("R8", 16'h0180, 16'h2000, 4'h0);
    run_one("R8", 16'h0100, 16'h2000, 4'h0);
    run_one("R8", 16'h01FF, 16'h2000, 4'h0);
    run_one("R8", 16'h017F, 16'hFFF0, 4'h0);
    run_one("R8", 16'h0180, 16'h0010, 4'h0);
    // R5 byte swap and R9 non-branch words
    run_one("R5", 16'h00C3, 16'h3000, 4'hF);
    run_one("R5", 16'h00FF, 16'h3002, 4'h0);
    run_one("R9", 16'h0040, 16'h3004, 4'h0);
    run_one("R9", 16'h0900, 16'h3006, 4'h0);
    run_one("R9", 16'h8700, 16'h3008, 4'h0);
    run_one("R9", 16'h0200, 16'h300A, 4'h4);

    // R10 and mixed random coverage
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 2 == 0) w[14:11] = 4'b0000;
      run_one("R10", w, 16'($urandom) & 16'hFFFE, 4'($urandom));
      if (out_taken && !out_is_branch) check("R10", "taken without branch", 1, 0);
    end

    // R3 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_instr = 16'h0110; in_pc = 16'h4000; in_flags = 4'h0; in_valid = 1'b1;
    @(negedge clk);
    in_instr = 16'h03F0; in_pc = 16'h5000; in_flags = 4'h4;
    check("R3", "in_ready during stall", int'(in_ready), 0);
    check("R3", "held target", int'(out_target), 16'h4020);
    @(negedge clk);
    check("R3", "target still held", int'(out_target), 16'h4020);
    check("R3", "valid still held", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", "second result target", int'(out_target), 16'h4FE0);
    check("R3", "second result taken", int'(out_taken), 1);
    @(negedge clk);
    check("R2", "drained", int'(out_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule